// File: doc/BRIEF.md
# Input Delay Tap Sweep Controller

This block trains the sampling point of a source-synchronous serial receiver. After a start pulse it walks a delay-tap setting from the lowest tap to the highest. For each tap it sends a one-cycle load strobe with the tap value to the delay element. It then waits a programmable settling time and asks an external lock checker for a verdict through a request/valid handshake. The verdict is a locked flag plus a small status code.

While sweeping, the controller tracks runs of consecutive taps that lock with an unchanged status code. A run closes when lock drops, when the code changes, or when the last tap is reached while still locked. The widest closed run is kept. When the sweep ends, the controller loads the midpoint of that run into the delay element once, raises a done flag and holds it. If no tap locked at all, it raises a fail flag instead and parks the delay at tap 0.

Top module: `tap_sweep_ctrl`

## Requirements
- R1: While reset is held and after its release, with no start pulse, `tap_load`, `chk_req`, `train_done` and `train_fail` are all low.
- R2: A start pulse sweeps every tap from 0 up to 2^TAP_W-1 in ascending order. Each tap is announced by a `tap_load` strobe that lasts one cycle, with `tap_value` equal to that tap. `tap_load` and `chk_req` are never high together.
- R3: `chk_req` first rises exactly `settle_cycles`+2 cycles after the cycle of the load strobe. It stays high until the cycle in which `chk_vld` is sampled high, and is low in the cycle after that. A `chk_vld` pulse while `chk_req` is low is ignored.
- R4: A run opens at the current tap when the verdict moves from unlocked to locked. It extends to each following tap that reports locked with the same status code.
- R5: A run closes at its last tap when the next verdict is unlocked. It also closes when the next verdict is locked with a different code; that tap then opens a new run.
- R6: If the highest tap reports locked, the open run closes with that tap as its upper end. This includes a run that opens on the highest tap.
- R7: The first closed run is stored. A later run replaces the stored one only if its width (upper tap minus lower tap) is strictly greater, so on a tie the earlier run is kept.
- R8: The chosen tap is floor((lower+upper)/2) of the stored run, computed with a sum one bit wider than a tap. It appears on `centre_tap` and on `tap_value` at the end of training.
- R9: At the end of the sweep, the first cycle with `train_done` high carries one `tap_load` strobe with the chosen tap. After that, `train_done` and `tap_value` hold until the next start pulse, with no further strobe.
- R10: If no tap reports locked, `train_fail` is high together with `train_done`, and both `tap_value` and `centre_tap` are 0.
- R11: A start pulse while `train_done` is high begins a new sweep from tap 0 and discards the previously stored run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep; accepted when idle or done |
| settle_cycles | input | CNT_W | Extra wait cycles between a tap load and the lock request |
| chk_req | output | 1 | Lock evaluation request to the checker |
| chk_vld | input | 1 | Checker verdict valid, sampled while `chk_req` is high |
| chk_locked | input | 1 | Checker verdict: link locked |
| chk_code | input | CODE_W | Checker status code accompanying the verdict |
| tap_load | output | 1 | One-cycle strobe to load `tap_value` into the delay element |
| tap_value | output | TAP_W | Tap to load; holds the final tap once done |
| train_done | output | 1 | Sweep complete, held until the next start |
| train_fail | output | 1 | Sweep complete and no tap locked |
| centre_tap | output | TAP_W | Midpoint of the widest stored run, 0 when none |

## Verification
Each tap strobe is followed by the request exactly `settle_cycles`+2 cycles later. The bench counts falling edges from the strobe and checks the request on precisely that edge. It holds the verdict back for a random 0 to 3 cycles and drives it at a falling edge, so the design samples it at the next rising edge. The request must then be low at the following falling edge. The next strobe comes three cycles after the verdict, and the done cycle comes three cycles after the last verdict. The bench waits for these events, with a bound, rather than assuming their timing. In the first done cycle it compares the strobe, the tap and the fail flag with a run-scan model of the per-tap verdict table. One cycle later it checks that the strobe has dropped while done holds.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETTLE, S_EVAL, S_RECORD, S_NEXT, S_DONE
  } tsw_state_e;
endpackage

// File: rtl/tsw_seq.sv
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int TAP_W  = 5,
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic              chk_vld,
  input  logic              chk_locked,
  input  logic [CODE_W-1:0] chk_code,
  input  logic              best_vld,
  input  logic [TAP_W-1:0]  best_centre,
  output logic              clr,
  output logic              smp_en,
  output logic              smp_locked,
  output logic [CODE_W-1:0] smp_code,
  output logic [TAP_W-1:0]  smp_tap,
  output logic              smp_last,
  output logic              tap_load,
  output logic [TAP_W-1:0]  tap_value,
  output logic              chk_req,
  output logic              train_done,
  output logic              train_fail
);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  tsw_state_e        state_q, state_d;
  logic [TAP_W-1:0]  cur_tap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              lk_q;
  logic [CODE_W-1:0] code_q;
  logic              first_q;
  logic              accept;
  logic              at_last;

  assign accept  = start && (state_q == S_IDLE || state_q == S_DONE);
  assign at_last = (cur_tap_q == TAP_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (accept) state_d = S_LOAD;
      S_LOAD:   state_d = S_SETTLE;
      S_SETTLE: if (cnt_q >= settle_cycles) state_d = S_EVAL;
      S_EVAL:   if (chk_vld) state_d = S_RECORD;
      S_RECORD: state_d = S_NEXT;
      S_NEXT:   state_d = at_last ? S_DONE : S_LOAD;
      S_DONE:   if (accept) state_d = S_LOAD;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cur_tap_q <= '0;
      cnt_q     <= '0;
      lk_q      <= 1'b0;
      code_q    <= '0;
      first_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= (state_q == S_NEXT);
      if (accept) cur_tap_q <= '0;
      else if (state_q == S_NEXT && !at_last) cur_tap_q <= cur_tap_q + 1'b1;
      if (state_q == S_LOAD) cnt_q <= '0;
      else if (state_q == S_SETTLE) cnt_q <= cnt_q + 1'b1;
      if (state_q == S_EVAL && chk_vld) begin
        lk_q   <= chk_locked;
        code_q <= chk_code;
      end
    end
  end

  assign clr        = accept;
  assign smp_en     = (state_q == S_RECORD);
  assign smp_locked = lk_q;
  assign smp_code   = code_q;
  assign smp_tap    = cur_tap_q;
  assign smp_last   = at_last;
  assign chk_req    = (state_q == S_EVAL);
  assign train_done = (state_q == S_DONE);
  assign train_fail = train_done && !best_vld;
  assign tap_load   = (state_q == S_LOAD) || (train_done && first_q);
  assign tap_value  = train_done ? (best_vld ? best_centre : '0) : cur_tap_q;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !chk_vld) |=> chk_req);
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && chk_vld) |=> !chk_req);
  p_load_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_load && chk_req));
  p_tap_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_NEXT && !at_last) |=> (tap_load && tap_value == $past(cur_tap_q) + 1'b1));
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (train_done && !start) |=> (train_done && !tap_load && $stable(tap_value)));
  p_fail_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
    train_fail |-> (tap_value == '0));
endmodule

// File: rtl/tsw_window.sv
module tsw_window #(
  parameter int TAP_W  = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_en,
  input  logic              smp_locked,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [TAP_W-1:0]  smp_tap,
  input  logic              smp_last,
  output logic              win_close,
  output logic [TAP_W-1:0]  win_lo,
  output logic [TAP_W-1:0]  win_hi
);
  logic              prev_lk_q;
  logic [CODE_W-1:0] prev_code_q;
  logic [TAP_W-1:0]  lo_q, hi_q;
  logic              ev_extend, ev_change, ev_lost, ev_open;

  assign ev_extend = smp_en && prev_lk_q && smp_locked && (smp_code == prev_code_q);
  assign ev_change = smp_en && prev_lk_q && smp_locked && (smp_code != prev_code_q);
  assign ev_lost   = smp_en && prev_lk_q && !smp_locked;
  assign ev_open   = smp_en && !prev_lk_q && smp_locked;

  always_comb begin
    win_close = 1'b0;
    win_lo    = lo_q;
    win_hi    = hi_q;
    if (ev_extend && smp_last) begin
      win_close = 1'b1;
      win_hi    = smp_tap;
    end else if (ev_change || ev_lost) begin
      win_close = 1'b1;
    end else if (ev_open && smp_last) begin
      win_close = 1'b1;
      win_lo    = smp_tap;
      win_hi    = smp_tap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lk_q   <= 1'b0;
      prev_code_q <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
    end else if (clr) begin
      prev_lk_q   <= 1'b0;
      prev_code_q <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
    end else if (smp_en) begin
      prev_lk_q   <= smp_locked;
      prev_code_q <= smp_code;
      if (ev_extend) hi_q <= smp_tap;
      if (ev_change || ev_open) begin
        lo_q <= smp_tap;
        hi_q <= smp_tap;
      end
    end
  end

  p_win_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |-> (win_lo <= win_hi));
  p_last_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && smp_last && smp_locked) |-> win_close);
  p_open_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !prev_lk_q) |-> !win_close || smp_last);
endmodule

// File: rtl/tsw_best.sv
module tsw_best #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cand_vld,
  input  logic [TAP_W-1:0] cand_lo,
  input  logic [TAP_W-1:0] cand_hi,
  output logic             best_vld,
  output logic [TAP_W-1:0] best_centre
);
  function automatic logic [TAP_W-1:0] width_of(input logic [TAP_W-1:0] lo,
                                                input logic [TAP_W-1:0] hi);
    return hi - lo;
  endfunction

  function automatic logic [TAP_W-1:0] mid_of(input logic [TAP_W-1:0] lo,
                                              input logic [TAP_W-1:0] hi);
    logic [TAP_W:0] sum;
    sum = {1'b0, lo} + {1'b0, hi};
    return sum[TAP_W:1];
  endfunction

  logic             vld_q;
  logic [TAP_W-1:0] lo_q, hi_q;
  logic [TAP_W-1:0] best_w, cand_w;
  logic             take;

  assign best_w = width_of(lo_q, hi_q);
  assign cand_w = width_of(cand_lo, cand_hi);
  assign take   = cand_vld && (!vld_q || (cand_w > best_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (clr) begin
      vld_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      lo_q  <= cand_lo;
      hi_q  <= cand_hi;
    end
  end

  assign best_vld    = vld_q;
  assign best_centre = mid_of(lo_q, hi_q);

  p_best_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(vld_q)) |-> (best_w >= $past(best_w)));
  p_tie_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !clr && cand_vld && cand_w <= best_w) |=> $stable(lo_q));
endmodule

// File: rtl/tap_sweep_ctrl.sv
module tap_sweep_ctrl #(
  parameter int TAP_W  = 5,
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  settle_cycles,
  output logic              chk_req,
  input  logic              chk_vld,
  input  logic              chk_locked,
  input  logic [CODE_W-1:0] chk_code,
  output logic              tap_load,
  output logic [TAP_W-1:0]  tap_value,
  output logic              train_done,
  output logic              train_fail,
  output logic [TAP_W-1:0]  centre_tap
);
  logic              clr, smp_en, smp_locked, smp_last;
  logic [CODE_W-1:0] smp_code;
  logic [TAP_W-1:0]  smp_tap;
  logic              win_close;
  logic [TAP_W-1:0]  win_lo, win_hi;
  logic              best_vld;
  logic [TAP_W-1:0]  best_centre;

  tsw_seq #(.TAP_W(TAP_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .chk_vld(chk_vld), .chk_locked(chk_locked), .chk_code(chk_code),
    .best_vld(best_vld), .best_centre(best_centre),
    .clr(clr), .smp_en(smp_en), .smp_locked(smp_locked), .smp_code(smp_code),
    .smp_tap(smp_tap), .smp_last(smp_last),
    .tap_load(tap_load), .tap_value(tap_value), .chk_req(chk_req),
    .train_done(train_done), .train_fail(train_fail)
  );

  tsw_window #(.TAP_W(TAP_W), .CODE_W(CODE_W)) u_window (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_en(smp_en),
    .smp_locked(smp_locked), .smp_code(smp_code), .smp_tap(smp_tap),
    .smp_last(smp_last), .win_close(win_close), .win_lo(win_lo), .win_hi(win_hi)
  );

  tsw_best #(.TAP_W(TAP_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cand_vld(win_close),
    .cand_lo(win_lo), .cand_hi(win_hi),
    .best_vld(best_vld), .best_centre(best_centre)
  );

  assign centre_tap = best_vld ? best_centre : '0;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!train_done && !chk_req && !tap_load && !$past(start) && !start && $past(!train_done && !chk_req && !tap_load && !smp_en)) |-> !train_fail);
endmodule

// File: tb/tap_sweep_ctrl_tb.sv
module tap_sweep_ctrl_tb;
  localparam int NT = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] settle_cycles = 8'd0;
  logic       chk_req;
  logic       chk_vld = 1'b0;
  logic       chk_locked = 1'b0;
  logic [2:0] chk_code = 3'd0;
  logic       tap_load;
  logic [4:0] tap_value;
  logic       train_done, train_fail;
  logic [4:0] centre_tap;

  int n_chk = 0;
  int n_fail = 0;
  bit         lk [NT];
  logic [2:0] cd [NT];

  always #2 clk = ~clk;

  tap_sweep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .chk_req(chk_req), .chk_vld(chk_vld), .chk_locked(chk_locked), .chk_code(chk_code),
    .tap_load(tap_load), .tap_value(tap_value), .train_done(train_done),
    .train_fail(train_fail), .centre_tap(centre_tap)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run scan over the verdict table: the widest run, the earliest on a tie
  task automatic ref_best(output int c, output bit f);
    bit bv = 0;
    int blo = 0, bhi = 0;
    int i = 0;
    while (i < NT) begin
      if (!lk[i]) i++;
      else begin
        int j = i;
        while (j + 1 < NT && lk[j+1] && cd[j+1] == cd[i]) j++;
        if (!bv || (j - i) > (bhi - blo)) begin
          bv = 1; blo = i; bhi = j;
        end
        i = j + 1;
      end
    end
    c = bv ? (blo + bhi) / 2 : 0;
    f = !bv;
  endtask

  task automatic clear_pat();
    for (int i = 0; i < NT; i++) begin lk[i] = 0; cd[i] = 3'd0; end
  endtask

  task automatic add_run(input int lo, input int hi, input logic [2:0] code);
    for (int i = lo; i <= hi; i++) begin lk[i] = 1; cd[i] = code; end
  endtask

  task automatic run_sweep(input int s, input string tag);
    int exp_c;
    bit exp_f;
    int n;
    ref_best(exp_c, exp_f);
    settle_cycles = 8'(s);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < NT; t++) begin
      n = 0;
      while (!tap_load && n < 200) begin @(negedge clk); n++; end
      check(tap_load == 1'b1 && tap_value == 5'(t), "R2 tap order", int'(tap_value), t);
      chk_vld = 1'b1; chk_locked = 1'b1; chk_code = ~cd[t];  // stray verdict, R3
      n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 1) chk_vld = 1'b0;
      end while (!chk_req && n < 300);
      check(n == s + 2, "R3 settle", n, s + 2);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      check(chk_req == 1'b1, "R3 req held", int'(chk_req), 1);
      chk_vld = 1'b1; chk_locked = lk[t]; chk_code = cd[t];
      @(negedge clk);
      chk_vld = 1'b0;
      check(chk_req == 1'b0, "R3 req drop", int'(chk_req), 0);
    end
    n = 0;
    while (!train_done && n < 50) begin @(negedge clk); n++; end
    check(train_done && tap_load, "R9 final strobe", int'(tap_load), 1);
    check(tap_value == 5'(exp_c), {tag, " R8 tap"}, int'(tap_value), exp_c);
    check(centre_tap == 5'(exp_c), {tag, " R8 centre"}, int'(centre_tap), exp_c);
    check(train_fail == exp_f, "R10 fail flag", int'(train_fail), int'(exp_f));
    @(negedge clk);
    check(!tap_load && train_done, "R9 single strobe", int'(tap_load), 0);
    repeat (3) @(negedge clk);
    check(train_done && tap_value == 5'(exp_c), "R9 hold", int'(tap_value), exp_c);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!tap_load && !chk_req && !train_done && !train_fail, "R1 in reset", int'(tap_load), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tap_load && !chk_req && !train_done && !train_fail, "R1 idle", int'(chk_req), 0);

    clear_pat(); add_run(10, 20, 3'd1);                     run_sweep(3, "R4");
    clear_pat(); add_run(5, 14, 3'd2); add_run(15, 25, 3'd5); run_sweep(1, "R5");
    clear_pat(); add_run(0, 3, 3'd0); add_run(20, 31, 3'd4);  run_sweep(0, "R6");
    clear_pat(); add_run(2, 6, 3'd3); add_run(12, 16, 3'd3);  run_sweep(2, "R7 tie");
    clear_pat(); add_run(7, 12, 3'd6);                      run_sweep(4, "R8 odd");
    clear_pat();                                            run_sweep(0, "R10 none");
    clear_pat(); add_run(31, 31, 3'd2);                     run_sweep(1, "R6 single");
    clear_pat(); add_run(0, 30, 3'd1);                      run_sweep(0, "R11 wide");
    clear_pat(); add_run(3, 4, 3'd1);                       run_sweep(0, "R11 narrow");
    for (int k = 0; k < 12; k++) begin
      clear_pat();
      for (int i = 0; i < NT; i++) begin
        lk[i] = ($urandom_range(0, 3) != 0);
        cd[i] = 3'($urandom_range(0, 1));
      end
      run_sweep($urandom_range(0, 5), "R7 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule